// File: doc/BRIEF.md
# Looped Three-Stage AES-128 Round Pipeline

This block encrypts 128-bit blocks with AES-128 using one hardware round that is cut into three register stages. A block passes through the loop eleven times. On each pass, the first stage XORs in the round key, the second applies the S-box substitution and the row rotation, and the third applies the column mixing before the block re-enters. Three blocks share the loop at once, one in each stage, so no stage ever sits idle.

The entry register is 132 bits wide. It holds the state together with a 4-bit round tag. The tag is shown on `key_idx`, and the key source must answer on `round_key` in the same cycle. The tag also tells the third stage to leave out the column mixing on the last pass.

A small sequencer waits for `keys_pending` to drop, then accepts three blocks on back-to-back cycles. The results appear 32 cycles after the first of those cycles. This gives three blocks in every 33-cycle period. Internally the state is kept row-major. Inputs are transposed from the usual column-major byte order on the way in and transposed back on the way out.

Top module: `aes_loop_round_pipe`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `take_in` = 0, `out_valid` = 0, `dout` = 0 and `key_idx` = 0.
- R2: While `keys_pending` is high and no batch period is running, `take_in` stays low.
- R3: After `keys_pending` is sampled low by an idle block, `take_in` is high for exactly 3 consecutive cycles, starting in the next cycle. `din` is captured at the clock edge that ends each of those cycles.
- R4: `dout` is the AES-128 ciphertext of the captured `din` under the key schedule supplied on `round_key`. Byte order: bits [127:120] of `din`, `round_key` and `dout` hold byte 0 of the standard byte sequence, and bits [7:0] hold byte 15. The known answer for key 000102…0f and plaintext 00112233…ff is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: `out_valid` first goes high 32 cycles after the first `take_in` cycle of a batch. It stays high for 3 cycles, and the results come out in the order the blocks were admitted.
- R6: `key_idx` carries the round tag of the block in the entry register. A block admitted in cycle t shows 0 in cycle t+1 and k in cycle t+1+3k, for k = 0..10. Key k must be presented on `round_key` in that same cycle.
- R7: The three blocks of one batch are processed independently. Different plaintexts in one batch each give their own ciphertext.
- R8: If `keys_pending` is low in the last cycle of a 33-cycle period, the next batch is admitted at once: `take_in` rises again 33 cycles after the previous rise.
- R9: If `keys_pending` is high in the last cycle of a period, no further block is admitted. Blocks already in the loop still complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keys_pending | input | 1 | High while the round-key schedule is not yet available |
| din | input | 128 | Plaintext block, captured when `take_in` is high |
| take_in | output | 1 | This cycle's `din` is loaded into the entry register |
| round_key | input | 128 | Round key selected by `key_idx`, expected combinationally |
| key_idx | output | TAG_W | Round tag of the block in the entry register |
| out_valid | output | 1 | `dout` holds a finished ciphertext |
| dout | output | 128 | Ciphertext block |

## Verification
The bench builds the block with its defaults, NUM_ROUNDS = 10 and TAG_W = 4. This allows a full AES-128 encryption to be compared with the published known answer and with a behavioural model in the bench. The bench runs two back-to-back batches with six different plaintexts. This exercises the overlap of one batch's outputs with the next batch's admission, and it exercises the stop after `keys_pending` rises in the middle of a period. The round-tag timeline on `key_idx` is recorded every cycle and compared with the 3-cycle step rule.

// File: rtl/aes_loop_pkg.sv
// Shared types and GF(2^8) helpers for the looped AES round.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aes_loop_pkg;
    localparam int LANES = 3;   // register stages in the loop

    typedef logic [7:0] byte_t;

    // Control word: bit2 skip mixing, bit1 result ready, bit0 load new block
    typedef struct packed {
        logic skip_mix;
        logic out_ready;
        logic load_new;
    } ctrl_t;

    // Multiply by 02: shift left, reduce with 0x1B on carry-out
    function automatic byte_t xt(input byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xt(p);
        end
        return acc;
    endfunction

    function automatic byte_t rotl8(input byte_t b, input int n);
        return byte_t'((b << n) | (b >> (8 - n)));
    endfunction

    // S-box: multiplicative inverse as x^254, then the affine map
    function automatic byte_t sbox(input byte_t x);
        byte_t inv;
        byte_t sq;
        inv = 8'h01;
        sq  = x;
        for (int i = 1; i < 8; i++) begin
            sq  = gmul(sq, sq);
            inv = gmul(inv, sq);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    // Swap column-major and row-major byte order (an involution)
    function automatic logic [127:0] transpose(input logic [127:0] v);
        logic [127:0] t;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                t[127-8*(4*r+c) -: 8] = v[127-8*(r+4*c) -: 8];
        return t;
    endfunction
endpackage

// File: rtl/aes_sub_shift.sv
// Byte substitution plus row rotation on a row-major state.
// Assumes byte (r,c) sits at index 4r+c, index 0 in bits [127:120].
module aes_sub_shift
    import aes_loop_pkg::*;
(
    input  logic [127:0] st_i,
    output logic [127:0] st_o
);
    // Sixteen parallel S-box lookups, row r rotated left by r bytes
    for (genvar r = 0; r < 4; r++) begin : g_row
        for (genvar c = 0; c < 4; c++) begin : g_col
            assign st_o[127-8*(4*r+c) -: 8] = sbox(st_i[127-8*(4*r+((c+r)%4)) -: 8]);
        end
    end
endmodule

// File: rtl/aes_mix_cols.sv
// Column mixing of a row-major state: each column times the fixed
// 02/03/01/01 circulant matrix over GF(2^8).
module aes_mix_cols
    import aes_loop_pkg::*;
(
    input  logic [127:0] st_i,
    output logic [127:0] st_o
);
    for (genvar c = 0; c < 4; c++) begin : g_col
        byte_t a [4];
        byte_t d [4];
        // Gather the column and its doubled bytes
        for (genvar r = 0; r < 4; r++) begin : g_get
            assign a[r] = st_i[127-8*(4*r+c) -: 8];
            assign d[r] = xt(a[r]);
        end
        // One output byte per row; 03*x is 02*x ^ x
        assign st_o[127-8*(0+c) -: 8]  = d[0] ^ d[1] ^ a[1] ^ a[2] ^ a[3];
        assign st_o[127-8*(4+c) -: 8]  = a[0] ^ d[1] ^ d[2] ^ a[2] ^ a[3];
        assign st_o[127-8*(8+c) -: 8]  = a[0] ^ a[1] ^ d[2] ^ d[3] ^ a[3];
        assign st_o[127-8*(12+c) -: 8] = d[0] ^ a[0] ^ a[1] ^ a[2] ^ d[3];
    end
endmodule

// File: rtl/aes_loop_ctrl.sv
// Batch sequencer. Admits LANES blocks at the start of each period of
// LANES*(NUM_ROUNDS+1) cycles and decodes tags into the control word.
// Assumes the key schedule is stable whenever keys_pending is low.
module aes_loop_ctrl
    import aes_loop_pkg::*;
#(
    parameter int NUM_ROUNDS = 10,
    parameter int TAG_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             keys_pending,
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TAG_W-1:0] lst_tag,
    output ctrl_t            ctrl
);
    localparam int PERIOD = LANES * (NUM_ROUNDS + 1);
    localparam int CW     = $clog2(PERIOD);

    logic          running;
    logic [CW-1:0] phase;

    // Period counter; the run decision is taken only at a period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            phase   <= '0;
        end else if (!running) begin
            phase <= '0;
            if (!keys_pending) running <= 1'b1;
        end else if (phase == CW'(PERIOD - 1)) begin
            phase   <= '0;
            running <= !keys_pending;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Control word decode
    always_comb begin
        ctrl.load_new  = running && (phase < CW'(LANES));
        ctrl.out_ready = ent_vld && (ent_tag == TAG_W'(NUM_ROUNDS));
        ctrl.skip_mix  = (lst_tag == TAG_W'(NUM_ROUNDS));
    end
endmodule

// File: rtl/aes_loop_round_pipe.sv
// Looped AES-128 round with three register stages and three blocks in
// flight. Entry register {state, tag} -> key XOR -> substitute/rotate
// -> mix (or bypass on the last pass) -> entry register.
// Assumes round_key answers key_idx within the same cycle.
module aes_loop_round_pipe
    import aes_loop_pkg::*;
#(
    parameter int NUM_ROUNDS = 10,
    parameter int TAG_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             keys_pending,
    input  logic [127:0]     din,
    output logic             take_in,
    input  logic [127:0]     round_key,
    output logic [TAG_W-1:0] key_idx,
    output logic             out_valid,
    output logic [127:0]     dout
);
    localparam int EW = 128 + TAG_W;

    ctrl_t            ctrl;
    logic [EW-1:0]    ent_q;
    logic             ent_vld;
    logic [127:0]     ark_q, sub_q;
    logic [TAG_W-1:0] ark_tag, sub_tag;
    logic             ark_vld, sub_vld;
    logic [127:0]     ark_st, sub_st, mix_st, loop_st;
    logic [TAG_W-1:0] ent_tag;

    assign ent_tag = ent_q[TAG_W-1:0];
    assign key_idx = ent_tag;
    assign take_in = ctrl.load_new;

    aes_loop_ctrl #(
        .NUM_ROUNDS (NUM_ROUNDS),
        .TAG_W      (TAG_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .keys_pending (keys_pending),
        .ent_vld      (ent_vld),
        .ent_tag      (ent_tag),
        .lst_tag      (sub_tag),
        .ctrl         (ctrl)
    );

    // Round key applied to the entry state
    assign ark_st = ent_q[EW-1:TAG_W] ^ transpose(round_key);

    // Entry register: new block with tag 0, or the looped-back state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q   <= '0;
            ent_vld <= 1'b0;
        end else if (ctrl.load_new) begin
            ent_q   <= {transpose(din), {TAG_W{1'b0}}};
            ent_vld <= 1'b1;
        end else begin
            ent_q   <= {loop_st, sub_tag};
            ent_vld <= sub_vld;
        end
    end

    // Second register: key-mixed state, tag advanced by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ark_q   <= '0;
            ark_tag <= '0;
            ark_vld <= 1'b0;
        end else begin
            ark_q   <= ark_st;
            ark_tag <= ent_tag + 1'b1;
            ark_vld <= ent_vld && !ctrl.out_ready;
        end
    end

    aes_sub_shift u_sub (
        .st_i (ark_q),
        .st_o (sub_st)
    );

    // Third register: substituted and rotated state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= '0;
            sub_tag <= '0;
            sub_vld <= 1'b0;
        end else begin
            sub_q   <= sub_st;
            sub_tag <= ark_tag;
            sub_vld <= ark_vld;
        end
    end

    aes_mix_cols u_mix (
        .st_i (sub_q),
        .st_o (mix_st)
    );

    assign loop_st = ctrl.skip_mix ? sub_q : mix_st;

    // Output register: final key XOR, back to column-major order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else begin
            out_valid <= ctrl.out_ready;
            if (ctrl.out_ready) dout <= transpose(ark_st);
        end
    end
endmodule

// File: rtl/aes_loop_round_pipe_chk.sv
// Protocol and timing checks for aes_loop_round_pipe, bound to it.
module aes_loop_round_pipe_chk
    import aes_loop_pkg::*;
#(
    parameter int NUM_ROUNDS = 10,
    parameter int TAG_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             keys_pending,
    input logic             take_in,
    input logic             out_valid,
    input logic             ent_vld,
    input logic [TAG_W-1:0] key_idx
);
    localparam int LAT = LANES * NUM_ROUNDS + 2;
    localparam int SW  = $clog2(LAT + 2) + 1;

    logic [2:0]    tin_run;
    logic          tin_prev;
    logic [SW-1:0] since_q;

    // Length of the current take_in burst and cycles since it began
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tin_run  <= '0;
            tin_prev <= 1'b0;
            since_q  <= '0;
        end else begin
            tin_prev <= take_in;
            if (take_in) tin_run <= (tin_run == 3'd7) ? tin_run : tin_run + 1'b1;
            else         tin_run <= '0;
            if (take_in && !tin_prev)            since_q <= SW'(1);
            else if (since_q != {SW{1'b1}})      since_q <= since_q + 1'b1;
        end
    end

    // R2
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keys_pending && !take_in |=> !take_in);

    // R3
    burst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_in |-> tin_run < 3'd3);

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(take_in) |-> tin_run == 3'd3);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> since_q == SW'(LAT));

    // R5
    out_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid ##1 out_valid);

    // R6
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld && key_idx < TAG_W'(NUM_ROUNDS) |->
            ##3 (key_idx == $past(key_idx, 3) + 1'b1));
endmodule

bind aes_loop_round_pipe aes_loop_round_pipe_chk #(
    .NUM_ROUNDS (NUM_ROUNDS),
    .TAG_W      (TAG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .keys_pending (keys_pending),
    .take_in      (take_in),
    .out_valid    (out_valid),
    .ent_vld      (ent_vld),
    .key_idx      (key_idx)
);

// File: tb/aes_loop_round_pipe_bench.sv
// Directed bench for aes_loop_round_pipe with a behavioural AES model.
module aes_loop_round_pipe_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         keys_pending = 1'b0;
    logic [127:0] din = '0;
    logic         take_in;
    logic [127:0] round_key;
    logic [3:0]   key_idx;
    logic         out_valid;
    logic [127:0] dout;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [7:0]   sb [256];
    logic [127:0] sched [11];
    logic [127:0] feed [6];
    int           tin_cyc [8];
    int           tin_n = 0;
    logic [127:0] out_dat [8];
    int           out_cyc [8];
    int           out_n = 0;
    logic [3:0]   kidx_hist [256];

    localparam logic [127:0] KEY  = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] PT0  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] CT0  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

    always #2.5ns clk = ~clk;

    aes_loop_round_pipe u_aes_loop_round_pipe (
        .clk (clk), .rst_n (rst_n), .keys_pending (keys_pending),
        .din (din), .take_in (take_in), .round_key (round_key),
        .key_idx (key_idx), .out_valid (out_valid), .dout (dout)
    );

    assign round_key = (key_idx <= 4'd10) ? sched[key_idx] : '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Feed blocks, log admissions, outputs and the tag timeline
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc < 256) kidx_hist[cyc] = key_idx;
            if (take_in && tin_n < 8) begin
                din = (tin_n < 6) ? feed[tin_n] : '0;
                tin_cyc[tin_n] = cyc;
                tin_n = tin_n + 1;
            end
            if (out_valid && out_n < 8) begin
                out_dat[out_n] = dout;
                out_cyc[out_n] = cyc;
                out_n = out_n + 1;
            end
        end
    end

    function automatic logic [7:0] rf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x, y, p;
        x = a; y = b; p = 8'h00;
        while (y != 8'h00) begin
            if (y[0]) p = p ^ x;
            x = x[7] ? (8'(x << 1) ^ 8'h1b) : 8'(x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv, s, cst;
            inv = 8'h00; cst = 8'h63;
            for (int y = 1; y < 256; y++)
                if (v != 0 && rf_mul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ cst[i];
            sb[v] = s;
        end
    endtask

    task automatic build_sched(input logic [127:0] k);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
                t[31:24] = t[31:24] ^ rc;
                rc = rf_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++)
            sched[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] rf_enc(input logic [127:0] pt);
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [127:0] v;
        v = pt ^ sched[0];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int i = 0; i < 16; i++) s[i] = sb[v[127-8*i -: 8]];
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    t[r+4*c] = s[r+4*((c+r)%4)];
            for (int c = 0; c < 4; c++) begin
                if (rnd < 10) begin
                    s[4*c]   = rf_mul(t[4*c],8'h02) ^ rf_mul(t[4*c+1],8'h03) ^ t[4*c+2] ^ t[4*c+3];
                    s[4*c+1] = t[4*c] ^ rf_mul(t[4*c+1],8'h02) ^ rf_mul(t[4*c+2],8'h03) ^ t[4*c+3];
                    s[4*c+2] = t[4*c] ^ t[4*c+1] ^ rf_mul(t[4*c+2],8'h02) ^ rf_mul(t[4*c+3],8'h03);
                    s[4*c+3] = rf_mul(t[4*c],8'h03) ^ t[4*c+1] ^ t[4*c+2] ^ rf_mul(t[4*c+3],8'h02);
                end else begin
                    for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
                end
            end
            for (int i = 0; i < 16; i++) v[127-8*i -: 8] = s[i];
            v = v ^ sched[rnd];
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        keys_pending = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 take_in in reset", 128'(take_in), 128'd0);
        check("R1 out_valid in reset", 128'(out_valid), 128'd0);
        check("R1 dout in reset", dout, 128'd0);
        check("R1 key_idx in reset", 128'(key_idx), 128'd0);
    endtask

    task automatic test_hold();
        int seen;
        seen = 0;
        keys_pending = 1'b1;
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (take_in || out_valid) seen++;
        end
        check("R2 no admission while keys pending", 128'(seen), 128'd0);
    endtask

    task automatic test_first_batch();
        int t0, errs;
        keys_pending = 1'b0;
        while (out_n < 3 && cyc < 400) @(negedge clk);
        @(negedge clk);
        t0 = tin_cyc[0];
        check("R3 second admission cycle", 128'(tin_cyc[1]), 128'(t0 + 1));
        check("R3 third admission cycle", 128'(tin_cyc[2]), 128'(t0 + 2));
        check("R5 first result latency", 128'(out_cyc[0]), 128'(t0 + 32));
        check("R5 results back to back", 128'(out_cyc[2]), 128'(out_cyc[0] + 2));
        check("R4 known answer", out_dat[0], CT0);
        check("R7 all-zero block", out_dat[1], rf_enc(feed[1]));
        check("R7 all-ones block", out_dat[2], rf_enc(feed[2]));
        errs = 0;
        for (int k = 0; k <= 10; k++)
            if (t0 + 1 + 3*k < 256 && kidx_hist[t0 + 1 + 3*k] !== 4'(k)) errs++;
        check("R6 tag timeline of first block", 128'(errs), 128'd0);
        errs = 0;
        for (int k = 0; k <= 10; k++)
            if (t0 + 3 + 3*k < 256 && kidx_hist[t0 + 3 + 3*k] !== 4'(k)) errs++;
        check("R6 tag timeline of third block", 128'(errs), 128'd0);
    endtask

    task automatic test_continuous_and_stop();
        int t0;
        t0 = tin_cyc[0];
        while (cyc < t0 + 40) @(negedge clk);
        keys_pending = 1'b1;
        check("R8 next batch after one period", 128'(tin_cyc[3]), 128'(t0 + 33));
        while (out_n < 6 && cyc < 600) @(negedge clk);
        check("R9 in-flight block 4 completes", out_dat[3], rf_enc(feed[3]));
        check("R7 block 5 of overlapped batch", out_dat[4], rf_enc(feed[4]));
        check("R7 block 6 of overlapped batch", out_dat[5], rf_enc(feed[5]));
        check("R5 second batch latency", 128'(out_cyc[3]), 128'(tin_cyc[3] + 32));
        repeat (50) @(negedge clk);
        check("R9 no admission after stop", 128'(tin_n), 128'd6);
        check("R9 no extra results", 128'(out_n), 128'd6);
    endtask

    initial begin
        build_sbox();
        build_sched(KEY);
        feed[0] = PT0;
        feed[1] = '0;
        feed[2] = '1;
        feed[3] = 128'h0123456789abcdeffedcba9876543210;
        feed[4] = 128'h80000000000000000000000000000001;
        feed[5] = 128'hdeadbeef0badf00dcafebabe12345678;
        check("R4 model known answer", rf_enc(PT0), CT0);
        test_reset();
        test_hold();
        test_first_batch();
        test_continuous_and_stop();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule